// File: doc/BRIEF.md
# USB Endpoint Status and Handshake Controller

This block holds the command/status state of every endpoint direction in a small USB device controller and picks the handshake each token receives. Firmware loads a per-direction command word and can abandon a buffer with a skip strobe. The packet engine reports completed data transactions, short packets, setup tokens and bus resets. The block answers with the current Active, Disabled, Stall and data-toggle bits of every direction. For the direction a token targets, it also gives a handshake choice and the remaining byte count.

Each endpoint has an OUT and an IN direction. Each direction is one slot, numbered `slot = 2*endpoint + dir` (dir 0 = OUT, 1 = IN), so slots 0 and 1 belong to control endpoint 0. Ownership of Active is split. Firmware can only set it. Hardware can only clear it. While it is set, the slot's word is locked against firmware.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset every slot has Active 0, Disabled 1, Stall 0, toggle 0 and byte count 0.
- R2: A firmware write (`wr_en`, `wr_slot`) to a slot whose Active is 0 loads Disabled, Stall, byte count and Active from `wr_word`. Bit CNT_W+4 is Active, CNT_W+3 is Disabled, CNT_W+2 is Stall, CNT_W+1 is toggle-reset, CNT_W is toggle-value, and bits CNT_W-1..0 are the byte count.
- R3: While a slot's Active is 1, a firmware write to it changes no field, including the toggle, so firmware can never clear Active.
- R4: A skip bit clears that slot's Active in the next cycle. When a skip and a write to the same slot arrive together, the skip is applied first and the write is accepted.
- R5: `hs_code` is 00 (ignore) when `tok_valid` is low, when `tok_slot` is not a valid slot, or when the slot is disabled. Otherwise it is 01 (data) when Active is 1, then 11 (STALL) when Stall is 1, else 10 (NAK). `hs_remain` shows the byte count of `tok_slot`.
- R6: A transfer (`xfer_valid`) on an active slot flips its toggle and lowers its count by `xfer_bytes`, saturating at zero.
- R7: Such a transfer clears Active when `xfer_short` is 1 or when the new count is zero.
- R8: A transfer on a slot whose Active is 0 leaves the slot unchanged.
- R9: A write that Active does not block, with toggle-reset 1, loads the toggle from toggle-value. With toggle-reset 0, the toggle is kept.
- R10: A setup token sets the toggle of slots 0 and 1 to 1. This overrides any other toggle update in that cycle.
- R11: A bus reset clears Active and the toggle of every slot. It wins over any write, skip or transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset event from the packet engine |
| wr_en | input | 1 | Firmware command-word write strobe |
| wr_slot | input | SLOT_W | Slot addressed by the write |
| wr_word | input | CNT_W+5 | Command word being written |
| skip | input | 2*N_EP | Per-slot skip strobes |
| setup_tok | input | 1 | Setup token received on endpoint 0 |
| tok_valid | input | 1 | A token addresses `tok_slot` |
| tok_slot | input | SLOT_W | Slot addressed by the token |
| xfer_valid | input | 1 | A data transaction completed |
| xfer_slot | input | SLOT_W | Slot of the completed transaction |
| xfer_bytes | input | CNT_W | Bytes moved in the transaction |
| xfer_short | input | 1 | The transaction was a short packet |
| ep_active | output | 2*N_EP | Active bit per slot |
| ep_disabled | output | 2*N_EP | Disabled bit per slot |
| ep_stall | output | 2*N_EP | Stall bit per slot |
| ep_toggle | output | 2*N_EP | Data toggle per slot |
| hs_code | output | 2 | Handshake for the token |
| hs_remain | output | CNT_W | Remaining bytes of `tok_slot` |

## Verification
Directed cases cover the ownership rules one at a time. A locked write tries to change every field. A skip coincides with a write. A long transfer tests saturation to zero, a short packet tests early release, and a transfer hits an idle slot. A bus reset collides with a write. Handshake checks walk one slot each through disabled, active-and-stalled, stalled-only and idle, which separates the Active-over-Stall priority from Disabled suppression. A long random phase then mixes writes, skips, transfers, setup tokens and bus resets on all slots, including invalid token slots. Same-slot collisions that the directed cases never line up are compared there against a bench model.

// File: rtl/usb_ep_pkg.sv
// Package: shared types for the endpoint status/handshake controller.
// Assumes: the control bits of a command word sit directly above the count.
package usb_ep_pkg;

    // Handshake choices returned for a token.
    typedef enum logic [1:0] {
        HS_IGNORE = 2'b00,
        HS_DATA   = 2'b01,
        HS_NAK    = 2'b10,
        HS_STALL  = 2'b11
    } hs_e;

    // Control bits of a command word, most significant first.
    typedef struct packed {
        logic active;
        logic disabled;
        logic stall;
        logic tog_rst;
        logic tog_val;
    } ep_ctl_t;

    localparam int CTL_W = 5;

endpackage

// File: rtl/usb_ep_slot.sv
// Module: state of one endpoint direction (one slot).
// What it does: holds Active, Disabled, Stall, toggle and byte count. It applies,
// in this order: bus reset, skip, then either a firmware write (only when Active
// is clear after the skip) or a transfer (only when Active stays set after the
// skip), and finally the setup-token toggle force on control slots.
// Assumes: wr_en and xfer_en are already decoded for this slot.
module usb_ep_slot
    import usb_ep_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter bit IS_CTRL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             skip,
    input  logic             wr_en,
    input  ep_ctl_t          wr_ctl,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             xfer_en,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic             xfer_short,
    input  logic             setup_tok,
    output logic             active,
    output logic             disabled,
    output logic             stall,
    output logic             toggle,
    output logic [CNT_W-1:0] count
);

    logic             setup_hit;
    logic             act_after_skip;
    logic [CNT_W-1:0] cnt_dec;
    logic             nxt_act, nxt_dis, nxt_stl, nxt_tog;
    logic [CNT_W-1:0] nxt_cnt;

    assign setup_hit      = IS_CTRL ? setup_tok : 1'b0;
    assign act_after_skip = active & ~skip;

    // Purpose: count left after a transfer, saturating at zero.
    assign cnt_dec = (count > xfer_bytes) ? (count - xfer_bytes) : '0;

    // Purpose: next-state selection in the fixed priority order.
    always_comb begin
        nxt_act = active;
        nxt_dis = disabled;
        nxt_stl = stall;
        nxt_tog = toggle;
        nxt_cnt = count;
        if (bus_rst) begin
            nxt_act = 1'b0;
            nxt_tog = 1'b0;
        end else begin
            if (skip) begin
                nxt_act = 1'b0;
            end
            if (wr_en && !act_after_skip) begin
                nxt_act = wr_ctl.active;
                nxt_dis = wr_ctl.disabled;
                nxt_stl = wr_ctl.stall;
                nxt_cnt = wr_cnt;
                if (wr_ctl.tog_rst) begin
                    nxt_tog = wr_ctl.tog_val;
                end
            end else if (xfer_en && act_after_skip) begin
                nxt_tog = ~toggle;
                nxt_cnt = cnt_dec;
                if (xfer_short || (cnt_dec == '0)) begin
                    nxt_act = 1'b0;
                end
            end
            if (setup_hit) begin
                nxt_tog = 1'b1;
            end
        end
    end

    // Purpose: slot state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            disabled <= 1'b1;
            stall    <= 1'b0;
            toggle   <= 1'b0;
            count    <= '0;
        end else begin
            active   <= nxt_act;
            disabled <= nxt_dis;
            stall    <= nxt_stl;
            toggle   <= nxt_tog;
            count    <= nxt_cnt;
        end
    end

    // R3: a write to an active slot cannot clear Active.
    p_fw_keeps_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active && wr_en && !skip && !bus_rst && !xfer_en |=> active);

    // R3: a write to an active slot leaves its fields untouched.
    p_locked_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active && wr_en && !skip && !bus_rst && !xfer_en
        |=> $stable(disabled) && $stable(stall) && $stable(count));

    // R4: a skip releases the buffer unless a write re-arms it at once.
    p_skip_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip && !(wr_en && wr_ctl.active) |=> !active);

    // R6: a transfer on an active slot flips the toggle.
    p_xfer_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && xfer_en && !skip && !bus_rst && !wr_en && !setup_hit
        |=> toggle != $past(toggle));

    // R6: the count never grows through a transfer.
    p_cnt_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && xfer_en && !skip && !bus_rst |=> count <= $past(count));

    // R8: a transfer on an idle slot changes nothing.
    p_idle_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active && xfer_en && !wr_en && !bus_rst
        |=> !active && $stable(count) && $stable(disabled));

    // R10: a setup token leaves the control toggles at one.
    p_setup_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        setup_hit && !bus_rst |=> toggle);

    // R11: a bus reset drops Active and the toggle.
    p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !active && !toggle);

endmodule

// File: rtl/usb_ep_hs_sel.sv
// Module: handshake selection for the slot a token addresses.
// What it does: decodes tok_slot to a one-hot select and picks one of IGNORE,
// DATA, STALL or NAK from that slot's bits (Disabled, then Active, then Stall).
// It also returns the slot's remaining count.
// Assumes: slot numbers at or above NS are not valid and select nothing.
module usb_ep_hs_sel
    import usb_ep_pkg::*;
#(
    parameter int NS     = 6,
    parameter int SLOT_W = 3,
    parameter int CNT_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tok_valid,
    input  logic [SLOT_W-1:0]   tok_slot,
    input  logic [NS-1:0]       act_v,
    input  logic [NS-1:0]       dis_v,
    input  logic [NS-1:0]       stl_v,
    input  logic [NS*CNT_W-1:0] cnt_flat,
    output hs_e                 hs,
    output logic [CNT_W-1:0]    remain
);

    logic [NS-1:0] sel_oh;
    logic          s_hit, s_act, s_dis, s_stl;

    // Purpose: one-hot decode of the addressed slot.
    for (genvar i = 0; i < NS; i++) begin : g_dec
        assign sel_oh[i] = (tok_slot == SLOT_W'(i));
    end

    assign s_hit = |sel_oh;
    assign s_act = |(sel_oh & act_v);
    assign s_dis = |(sel_oh & dis_v);
    assign s_stl = |(sel_oh & stl_v);

    // Purpose: gather the count of the selected slot.
    always_comb begin
        remain = '0;
        for (int i = 0; i < NS; i++) begin
            if (sel_oh[i]) begin
                remain = remain | cnt_flat[i*CNT_W +: CNT_W];
            end
        end
    end

    // Purpose: priority choice of the handshake.
    always_comb begin
        if (!tok_valid || !s_hit || s_dis) begin
            hs = HS_IGNORE;
        end else if (s_act) begin
            hs = HS_DATA;
        end else if (s_stl) begin
            hs = HS_STALL;
        end else begin
            hs = HS_NAK;
        end
    end

    // R5: at most one slot is ever selected.
    p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R5: no handshake without a token.
    p_no_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |-> hs == HS_IGNORE);

    // R5: STALL only from an idle, enabled, stalled slot (Active wins).
    p_stall_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs == HS_STALL |-> (sel_oh & act_v) == '0 && (sel_oh & stl_v) != '0
                          && (sel_oh & dis_v) == '0);

endmodule

// File: rtl/usb_ep_ctrl.sv
// Module: top of the endpoint status and handshake controller.
// What it does: decodes firmware writes and transfer events onto 2*N_EP slots
// (slot = 2*endpoint + direction, slots 0/1 being control endpoint 0), keeps
// each slot's state and answers tokens with a handshake choice.
// Assumes: one write and one transfer at most per cycle; skip is per slot.
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter int N_EP   = 3,
    parameter int CNT_W  = 10,
    parameter int NS     = 2 * N_EP,
    parameter int SLOT_W = (NS > 1) ? $clog2(NS) : 1,
    parameter int WORD_W = CNT_W + CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [NS-1:0]     skip,
    input  logic              setup_tok,
    input  logic              tok_valid,
    input  logic [SLOT_W-1:0] tok_slot,
    input  logic              xfer_valid,
    input  logic [SLOT_W-1:0] xfer_slot,
    input  logic [CNT_W-1:0]  xfer_bytes,
    input  logic              xfer_short,
    output logic [NS-1:0]     ep_active,
    output logic [NS-1:0]     ep_disabled,
    output logic [NS-1:0]     ep_stall,
    output logic [NS-1:0]     ep_toggle,
    output logic [1:0]        hs_code,
    output logic [CNT_W-1:0]  hs_remain
);

    ep_ctl_t          wr_ctl;
    logic [CNT_W-1:0] wr_cnt;
    logic [NS*CNT_W-1:0] cnt_flat;
    hs_e              hs;

    assign wr_ctl = ep_ctl_t'(wr_word[WORD_W-1:CNT_W]);
    assign wr_cnt = wr_word[CNT_W-1:0];

    // Purpose: one state slot per endpoint direction.
    for (genvar i = 0; i < NS; i++) begin : g_slot
        logic wr_hit, xfer_hit;
        assign wr_hit   = wr_en && (wr_slot == SLOT_W'(i));
        assign xfer_hit = xfer_valid && (xfer_slot == SLOT_W'(i));

        usb_ep_slot #(
            .CNT_W   (CNT_W),
            .IS_CTRL (i < 2)
        ) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .bus_rst    (bus_rst),
            .skip       (skip[i]),
            .wr_en      (wr_hit),
            .wr_ctl     (wr_ctl),
            .wr_cnt     (wr_cnt),
            .xfer_en    (xfer_hit),
            .xfer_bytes (xfer_bytes),
            .xfer_short (xfer_short),
            .setup_tok  (setup_tok),
            .active     (ep_active[i]),
            .disabled   (ep_disabled[i]),
            .stall      (ep_stall[i]),
            .toggle     (ep_toggle[i]),
            .count      (cnt_flat[i*CNT_W +: CNT_W])
        );
    end

    usb_ep_hs_sel #(
        .NS     (NS),
        .SLOT_W (SLOT_W),
        .CNT_W  (CNT_W)
    ) i_hs_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_slot  (tok_slot),
        .act_v     (ep_active),
        .dis_v     (ep_disabled),
        .stl_v     (ep_stall),
        .cnt_flat  (cnt_flat),
        .hs        (hs),
        .remain    (hs_remain)
    );

    assign hs_code = hs;

    // R1: state registers leave reset with every slot disabled and idle.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> ep_active == '0 && ep_disabled == '1 && ep_toggle == '0);

endmodule

// File: tb/test_usb_ep_ctrl.sv
// Bench: directed corner cases, then seeded random traffic, all compared with
// a bench model written from the requirements.
module test_usb_ep_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_EP   = 3;
    localparam int NS     = 2 * N_EP;
    localparam int CNT_W  = 10;
    localparam int SLOT_W = $clog2(NS);
    localparam int WORD_W = CNT_W + 5;
    localparam int N_RAND = 3000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_rst;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [WORD_W-1:0] wr_word;
    logic [NS-1:0]     skip;
    logic              setup_tok;
    logic              tok_valid;
    logic [SLOT_W-1:0] tok_slot;
    logic              xfer_valid;
    logic [SLOT_W-1:0] xfer_slot;
    logic [CNT_W-1:0]  xfer_bytes;
    logic              xfer_short;
    logic [NS-1:0]     ep_active, ep_disabled, ep_stall, ep_toggle;
    logic [1:0]        hs_code;
    logic [CNT_W-1:0]  hs_remain;

    usb_ep_ctrl #(.N_EP(N_EP), .CNT_W(CNT_W)) i_usb_ep_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_word(wr_word), .skip(skip),
        .setup_tok(setup_tok), .tok_valid(tok_valid), .tok_slot(tok_slot),
        .xfer_valid(xfer_valid), .xfer_slot(xfer_slot),
        .xfer_bytes(xfer_bytes), .xfer_short(xfer_short),
        .ep_active(ep_active), .ep_disabled(ep_disabled),
        .ep_stall(ep_stall), .ep_toggle(ep_toggle),
        .hs_code(hs_code), .hs_remain(hs_remain)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    bit m_act [NS];
    bit m_dis [NS];
    bit m_stl [NS];
    bit m_tog [NS];
    int m_cnt [NS];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkword(bit a, bit d, bit s, bit tr,
                                                 bit tv, int cnt);
        return {a, d, s, tr, tv, CNT_W'(cnt)};
    endfunction

    // R5 handshake from the model state.
    function automatic int hs_exp(bit v, int slot);
        if (!v || slot >= NS) return 0;
        if (m_dis[slot]) return 0;
        if (m_act[slot]) return 1;
        if (m_stl[slot]) return 3;
        return 2;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_act[i] = 0; m_dis[i] = 1; m_stl[i] = 0; m_tog[i] = 0; m_cnt[i] = 0;
        end
    endtask

    // Model of one clock edge, built from R2 to R11.
    task automatic model_step();
        for (int i = 0; i < NS; i++) begin
            bit a;
            int nc;
            if (bus_rst) begin
                m_act[i] = 0; m_tog[i] = 0;
            end else begin
                a = m_act[i] && !skip[i];
                m_act[i] = a;
                if (wr_en && int'(wr_slot) == i && !a) begin
                    m_act[i] = wr_word[CNT_W+4];
                    m_dis[i] = wr_word[CNT_W+3];
                    m_stl[i] = wr_word[CNT_W+2];
                    m_cnt[i] = int'(wr_word[CNT_W-1:0]);
                    if (wr_word[CNT_W+1]) m_tog[i] = wr_word[CNT_W];
                end else if (xfer_valid && int'(xfer_slot) == i && a) begin
                    m_tog[i] = !m_tog[i];
                    nc = m_cnt[i] - int'(xfer_bytes);
                    if (nc < 0) nc = 0;
                    m_cnt[i] = nc;
                    if (xfer_short || nc == 0) m_act[i] = 0;
                end
                if (setup_tok && i < 2) m_tog[i] = 1;
            end
        end
    endtask

    task automatic idle();
        bus_rst = 0; wr_en = 0; wr_slot = '0; wr_word = '0; skip = '0;
        setup_tok = 0; tok_valid = 0; tok_slot = '0; xfer_valid = 0;
        xfer_slot = '0; xfer_bytes = '0; xfer_short = 0;
    endtask

    task automatic cmp_state(string tag);
        for (int i = 0; i < NS; i++) begin
            chk(tag, $sformatf("active[%0d]", i), int'(ep_active[i]), int'(m_act[i]));
            chk(tag, $sformatf("disabled[%0d]", i), int'(ep_disabled[i]), int'(m_dis[i]));
            chk(tag, $sformatf("stall[%0d]", i), int'(ep_stall[i]), int'(m_stl[i]));
            chk(tag, $sformatf("toggle[%0d]", i), int'(ep_toggle[i]), int'(m_tog[i]));
        end
    endtask

    // Check the handshake now, clock once, then check the new state.
    task automatic cycle(string tag);
        int es;
        #1;
        es = int'(tok_slot);
        chk(tag, "hs_code", int'(hs_code), hs_exp(tok_valid, es));
        chk(tag, "hs_remain", int'(hs_remain), (es < NS) ? m_cnt[es] : 0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp_state(tag);
        idle();
    endtask

    // Check only the count of one slot, via the token port (no token raised).
    task automatic peek_cnt(string tag, int slot, int exp);
        tok_slot = SLOT_W'(slot);
        #1;
        chk(tag, $sformatf("count[%0d]", slot), int'(hs_remain), exp);
        tok_slot = '0;
    endtask

    task automatic do_write(int slot, bit a, bit d, bit s, bit tr, bit tv, int cnt);
        wr_en = 1; wr_slot = SLOT_W'(slot); wr_word = mkword(a, d, s, tr, tv, cnt);
    endtask

    task automatic do_xfer(int slot, int bytes, bit sh);
        xfer_valid = 1; xfer_slot = SLOT_W'(slot);
        xfer_bytes = CNT_W'(bytes); xfer_short = sh;
    endtask

    task automatic do_tok(int slot);
        tok_valid = 1; tok_slot = SLOT_W'(slot);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, and a token to disabled slot 0 is ignored.
        cmp_state("R1");
        peek_cnt("R1", 0, 0);
        do_tok(0);
        cycle("R1");

        // R2: arm slot 2 with 100 bytes.
        do_write(2, 1, 0, 0, 0, 0, 100);
        cycle("R2");
        peek_cnt("R2", 2, 100);
        do_tok(2);                         // R5: active slot sends data
        cycle("R5");

        // R3: write to active slot 2 tries to change every field.
        do_write(2, 0, 1, 1, 1, 1, 5);
        cycle("R3");
        peek_cnt("R3", 2, 100);

        // R6: 30 bytes move, toggle flips.
        do_xfer(2, 30, 0);
        cycle("R6");
        peek_cnt("R6", 2, 70);

        // R7: oversize transfer saturates to zero and releases Active.
        do_xfer(2, 200, 0);
        cycle("R7");
        peek_cnt("R7", 2, 0);

        // R8: transfer on now-idle slot 2 is ignored.
        do_xfer(2, 1, 1);
        cycle("R8");
        peek_cnt("R8", 2, 0);

        // R7: short packet releases Active with bytes left.
        do_write(3, 1, 0, 0, 0, 0, 64);
        cycle("R7");
        do_xfer(3, 10, 1);
        cycle("R7");
        peek_cnt("R7", 3, 54);

        // R5: stalled idle slot 3, active+stalled slot 4, plain slot 5.
        do_write(3, 0, 0, 1, 0, 0, 0);
        cycle("R5");
        do_tok(3);
        cycle("R5");
        do_write(4, 1, 0, 1, 0, 0, 40);
        cycle("R5");
        do_tok(4);
        cycle("R5");
        do_write(5, 0, 0, 0, 0, 0, 0);
        cycle("R5");
        do_tok(5);
        cycle("R5");
        do_tok(7);                         // R5: invalid slot number
        cycle("R5");

        // R4: skip plus write on active slot 4: write accepted.
        skip[4] = 1;
        do_write(4, 0, 1, 0, 0, 0, 9);
        cycle("R4");
        peek_cnt("R4", 4, 9);
        do_write(4, 1, 0, 0, 0, 0, 20);
        cycle("R4");
        skip[4] = 1;                       // R4: skip alone
        cycle("R4");

        // R9: toggle-reset loads value; without it the toggle is kept.
        do_write(5, 0, 0, 0, 1, 1, 0);
        cycle("R9");
        do_write(5, 0, 0, 0, 0, 0, 0);
        cycle("R9");

        // R10: setup token forces both control toggles.
        setup_tok = 1;
        cycle("R10");

        // R11: bus reset beats a write.
        do_write(1, 1, 0, 0, 0, 0, 7);
        cycle("R11");
        bus_rst = 1;
        do_write(0, 1, 0, 1, 1, 1, 33);
        cycle("R11");
        peek_cnt("R11", 0, 0);

        // Random phase with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < N_RAND; n++) begin
            bus_rst    = ($urandom_range(0, 99) < 2);
            wr_en      = ($urandom_range(0, 99) < 30);
            wr_slot    = SLOT_W'($urandom_range(0, NS - 1));
            wr_word    = mkword($urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                                ($urandom_range(0, 3) == 0), $urandom_range(0, 1),
                                $urandom_range(0, 1),
                                ($urandom_range(0, 9) == 0) ? $urandom_range(0, 1023)
                                                            : $urandom_range(0, 80));
            for (int i = 0; i < NS; i++) skip[i] = ($urandom_range(0, 99) < 5);
            setup_tok  = ($urandom_range(0, 99) < 5);
            tok_valid  = ($urandom_range(0, 99) < 70);
            tok_slot   = SLOT_W'($urandom_range(0, (1 << SLOT_W) - 1));
            xfer_valid = ($urandom_range(0, 99) < 40);
            xfer_slot  = SLOT_W'($urandom_range(0, NS - 1));
            xfer_bytes = CNT_W'($urandom_range(0, 64));
            xfer_short = ($urandom_range(0, 99) < 20);
            cycle("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule